// File: doc/BRIEF.md
# Conversion Result History and Status Bank

This block keeps a short history of packed conversion results next to a status word and an interrupt line. Each result arrives as a pair of 16-bit words: a high word and a low word. When a new pair arrives, the older pairs move one place down and the oldest pair is dropped. The newest pair and the older slots can be read through a plain register port.

The register port takes an address, separate read and write strobes, and 16-bit data. Reads come from an internal pointer, which is loaded from the address bus. When auto-increment is enabled, the pointer steps forward after each read, so a host can fetch a whole block of words in one pass.

A status word reports four things: a ready flag, an overload flag, and the high and low threshold flags that come with each result. An interrupt output is raised according to a selectable cadence, and its active level is programmable. The interrupt stays raised until software reads the status word.

Top module: `result_hist_bank`

## Requirements
- R1: Address 0 returns the newest high word and address 1 the newest low word. Addresses 2/3, 4/5 and 6/7 return the high/low words of history slots 0, 1 and 2. A strobe on `res_valid_i` moves every pair down one place in the same cycle: slot 2 takes slot 1, slot 1 takes slot 0, slot 0 takes the old newest pair, and the newest pair takes the incoming words.
- R2: `ptr_ld_i` loads the read pointer from `addr_i`. `rdata_o` presents the word at the pointer in the cycle after `rd_i`. While auto-increment (config bit 0) is set, each read advances the pointer by one. While it is clear, the pointer holds.
- R3: Each result strobe sets the ready flag, which is bit 2 of the status word at address 0xC.
- R4: The ready flag is cleared by a read of 0xC, and that read still returns the flag as 1. It is also cleared by a write of a non-zero value to 0xC. A write of zero leaves it set. A result strobe in the same cycle as a clear leaves the flag set.
- R5: Status bit 3 is the overload flag, bit 1 the high flag and bit 0 the low flag, each captured with every result. Bits 15:4 read zero.
- R6: The config word at 0xA holds auto-increment in bit 0, the interrupt mode in bits 3:2 and the interrupt polarity in bit 4. It resets to 0x0001. All other bits read zero.
- R7: The interrupt is raised according to the mode:
  - mode 1: on every result;
  - mode 3: on every fourth result counted since the last write to 0xA;
  - mode 0: on a result that carries the high or low flag;
  - mode 2: never.
- R8: Once raised, the interrupt holds until a read of 0xC. A write to 0xC does not release it. A new interrupt event in the same cycle as that read keeps it raised.
- R9: With polarity 1 the interrupt output is high when raised. With polarity 0 it is low when raised. After reset the output idles high.
- R10: Reads of unmapped addresses (8, 9, 0xB, 0xD to 0xF) return zero. Writes to history or unmapped addresses change nothing.
- R11: After reset all history words and the status word read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | New result strobe |
| res_hi_i | input | 16 | Incoming high word |
| res_lo_i | input | 16 | Incoming low word |
| ovl_i | input | 1 | Overload flag of incoming result |
| flag_h_i | input | 1 | High-threshold flag of incoming result |
| flag_l_i | input | 1 | Low-threshold flag of incoming result |
| addr_i | input | 4 | Register address |
| ptr_ld_i | input | 1 | Load read pointer from addr_i |
| rd_i | input | 1 | Read strobe (at pointer) |
| wr_i | input | 1 | Write strobe (at addr_i) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| int_o | output | 1 | Interrupt output |

## Verification
The bench builds the block with its default parameters: three history slots, a fourth-result interrupt period of four, and a 4-bit address. With these values, a single burst that starts at address 0 crosses every history word and runs on into the first unmapped address. Five results are enough to push data out of the oldest slot. The mode-3 cadence can be observed as three silent results followed by one that raises the interrupt.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [1:0] {
    IRQ_ALERT = 2'd0,
    IRQ_EACH  = 2'd1,
    IRQ_NONE  = 2'd2,
    IRQ_QUAD  = 2'd3
  } irq_mode_e;
endpackage

// File: rtl/rhb_history.sv
module rhb_history #(
  parameter int unsigned DW    = 16,
  parameter int unsigned SLOTS = 3,
  localparam int unsigned ENTRIES = SLOTS + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] lo_i,
  output logic [DW-1:0] hi_o [ENTRIES],
  output logic [DW-1:0] lo_o [ENTRIES]
);
  logic [DW-1:0] hi_q [ENTRIES];
  logic [DW-1:0] lo_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q[0] <= '0;
      lo_q[0] <= '0;
    end else if (push_i) begin
      hi_q[0] <= hi_i;
      lo_q[0] <= lo_i;
    end
  end

  for (genvar i = 1; i < ENTRIES; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q[i] <= '0;
        lo_q[i] <= '0;
      end else if (push_i) begin
        hi_q[i] <= hi_q[i-1];
        lo_q[i] <= lo_q[i-1];
      end
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  // R1
  hist_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (hi_q[1] == $past(hi_q[0])) && (lo_q[1] == $past(lo_q[0])));
endmodule

// File: rtl/rhb_status_irq.sv
module rhb_status_irq
  import rhb_pkg::*;
#(
  parameter int unsigned QUAD_N = 4,
  localparam int unsigned CW = (QUAD_N > 1) ? $clog2(QUAD_N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              ovl_i,
  input  logic              fh_i,
  input  logic              fl_i,
  input  logic              stat_rd_i,
  input  logic              stat_wr_nz_i,
  input  logic              cfg_wr_i,
  input  irq_mode_e         irq_mode_i,
  input  logic              irq_pol_i,
  output logic [WORD_W-1:0] status_o,
  output logic              int_o
);
  logic          rdy_q, ovl_q, fh_q, fl_q, irq_q, evt;
  logic [CW-1:0] cnt_q;
  logic          quad_hit;

  assign quad_hit = push_i && (cnt_q == CW'(QUAD_N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cfg_wr_i) cnt_q <= '0;
    else if (push_i)   cnt_q <= quad_hit ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    unique case (irq_mode_i)
      IRQ_EACH:  evt = push_i;
      IRQ_QUAD:  evt = quad_hit;
      IRQ_ALERT: evt = push_i && (fh_i || fl_i);
      default:   evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b0;
      ovl_q <= 1'b0;
      fh_q  <= 1'b0;
      fl_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (push_i) begin
        rdy_q <= 1'b1;
        ovl_q <= ovl_i;
        fh_q  <= fh_i;
        fl_q  <= fl_i;
      end else if (stat_rd_i || stat_wr_nz_i) begin
        rdy_q <= 1'b0;
      end
      if (evt)            irq_q <= 1'b1;
      else if (stat_rd_i) irq_q <= 1'b0;
    end
  end

  assign status_o = {{(WORD_W-4){1'b0}}, ovl_q, rdy_q, fh_q, fl_q};
  assign int_o    = irq_pol_i ? irq_q : ~irq_q;

  // R3
  rdy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> rdy_q);
  // R4
  rdy_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_rd_i || stat_wr_nz_i) && !push_i) |=> !rdy_q);
  // R8
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !stat_rd_i) |=> irq_q);
  // R7
  irq_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_q && irq_mode_i == IRQ_NONE) |=> !irq_q);
endmodule

// File: rtl/rhb_regport.sv
module rhb_regport
  import rhb_pkg::*;
#(
  parameter int unsigned   AW        = 4,
  parameter int unsigned   ENTRIES   = 4,
  parameter logic [AW-1:0] CFG_ADDR  = 'hA,
  parameter logic [AW-1:0] STAT_ADDR = 'hC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              ptr_ld_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] hi_i [ENTRIES],
  input  logic [WORD_W-1:0] lo_i [ENTRIES],
  input  logic [WORD_W-1:0] status_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              stat_rd_o,
  output logic              stat_wr_nz_o,
  output logic              cfg_wr_o,
  output irq_mode_e         irq_mode_o,
  output logic              irq_pol_o
);
  logic [AW-1:0]     ptr_q;
  logic              burst_q, pol_q;
  irq_mode_e         mode_q;
  logic [WORD_W-1:0] rmux, cfg_word;

  assign cfg_wr_o     = wr_i && (addr_i == CFG_ADDR);
  assign stat_wr_nz_o = wr_i && (addr_i == STAT_ADDR) && (|wdata_i);
  assign stat_rd_o    = rd_i && (ptr_q == STAT_ADDR);
  assign cfg_word     = {{(WORD_W-5){1'b0}}, pol_q, mode_q, 1'b0, burst_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_q <= 1'b1;
      pol_q   <= 1'b0;
      mode_q  <= IRQ_ALERT;
    end else if (cfg_wr_o) begin
      burst_q <= wdata_i[0];
      mode_q  <= irq_mode_e'(wdata_i[3:2]);
      pol_q   <= wdata_i[4];
    end
  end

  always_comb begin
    rmux = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (ptr_q == AW'(2*k))     rmux = hi_i[k];
      if (ptr_q == AW'(2*k + 1)) rmux = lo_i[k];
    end
    if (ptr_q == CFG_ADDR)  rmux = cfg_word;
    if (ptr_q == STAT_ADDR) rmux = status_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      rdata_o <= '0;
    end else begin
      if (rd_i) rdata_o <= rmux;
      if (ptr_ld_i)            ptr_q <= addr_i;
      else if (rd_i && burst_q) ptr_q <= ptr_q + 1'b1;
    end
  end

  assign irq_mode_o = mode_q;
  assign irq_pol_o  = pol_q;

  // R2
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && burst_q && !ptr_ld_i) |=> ptr_q == AW'($past(ptr_q) + 1'b1));
  // R2
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !burst_q && !ptr_ld_i) |=> $stable(ptr_q));
endmodule

// File: rtl/result_hist_bank.sv
module result_hist_bank
  import rhb_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned SLOTS  = 3,
  parameter int unsigned QUAD_N = 4,
  localparam int unsigned ENTRIES = SLOTS + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_valid_i,
  input  logic [WORD_W-1:0] res_hi_i,
  input  logic [WORD_W-1:0] res_lo_i,
  input  logic              ovl_i,
  input  logic              flag_h_i,
  input  logic              flag_l_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ptr_ld_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              int_o
);
  logic [WORD_W-1:0] hi_w [ENTRIES];
  logic [WORD_W-1:0] lo_w [ENTRIES];
  logic [WORD_W-1:0] status_w;
  logic              stat_rd, stat_wr_nz, cfg_wr, irq_pol;
  irq_mode_e         irq_mode;

  rhb_history #(.DW(WORD_W), .SLOTS(SLOTS)) u_hist (
    .clk_i, .rst_ni,
    .push_i (res_valid_i),
    .hi_i   (res_hi_i),
    .lo_i   (res_lo_i),
    .hi_o   (hi_w),
    .lo_o   (lo_w)
  );

  rhb_status_irq #(.QUAD_N(QUAD_N)) u_stat (
    .clk_i, .rst_ni,
    .push_i       (res_valid_i),
    .ovl_i        (ovl_i),
    .fh_i         (flag_h_i),
    .fl_i         (flag_l_i),
    .stat_rd_i    (stat_rd),
    .stat_wr_nz_i (stat_wr_nz),
    .cfg_wr_i     (cfg_wr),
    .irq_mode_i   (irq_mode),
    .irq_pol_i    (irq_pol),
    .status_o     (status_w),
    .int_o        (int_o)
  );

  rhb_regport #(
    .AW(ADDR_W), .ENTRIES(ENTRIES),
    .CFG_ADDR(ADDR_W'(4'hA)), .STAT_ADDR(ADDR_W'(4'hC))
  ) u_port (
    .clk_i, .rst_ni,
    .addr_i, .ptr_ld_i, .rd_i, .wr_i, .wdata_i,
    .hi_i         (hi_w),
    .lo_i         (lo_w),
    .status_i     (status_w),
    .rdata_o      (rdata_o),
    .stat_rd_o    (stat_rd),
    .stat_wr_nz_o (stat_wr_nz),
    .cfg_wr_o     (cfg_wr),
    .irq_mode_o   (irq_mode),
    .irq_pol_o    (irq_pol)
  );
endmodule

// File: tb/result_hist_bank_tb.sv
module result_hist_bank_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        res_valid = 0, ovl = 0, fh = 0, fl = 0;
  logic [15:0] res_hi = 0, res_lo = 0, wdata = 0;
  logic [3:0]  addr = 0;
  logic        ptr_ld = 0, rd = 0, wr = 0;
  logic [15:0] rdata;
  logic        int_w;

  int checks = 0, failures = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] m_hi[4], m_lo[4];

  always #5 clk = ~clk;

  result_hist_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .res_valid_i(res_valid), .res_hi_i(res_hi),
    .res_lo_i(res_lo), .ovl_i(ovl), .flag_h_i(fh), .flag_l_i(fl),
    .addr_i(addr), .ptr_ld_i(ptr_ld), .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .int_o(int_w)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each read word one edge after its strobe
  always @(posedge clk) begin
    if (rst_n && rd) begin
      #2;
      if (exp_q.size() == 0) begin
        chk(rdata, 16'hxxxx, "R2 unexpected read");
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata, e, t);
      end
    end
  end

  task automatic set_ptr(input logic [3:0] a);
    addr = a; ptr_ld = 1;
    @(negedge clk) ptr_ld = 0;
  endtask

  task automatic rd_exp(input logic [15:0] e, input string t);
    rd = 1; exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk) rd = 0;
  endtask

  task automatic rd_at(input logic [3:0] a, input logic [15:0] e, input string t);
    set_ptr(a);
    rd_exp(e, t);
  endtask

  task automatic wreg(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1;
    @(negedge clk) wr = 0;
  endtask

  task automatic model_push(input logic [15:0] h, input logic [15:0] l);
    for (int i = 3; i > 0; i--) begin
      m_hi[i] = m_hi[i-1];
      m_lo[i] = m_lo[i-1];
    end
    m_hi[0] = h; m_lo[0] = l;
  endtask

  task automatic conv(input logic [15:0] h, input logic [15:0] l,
                      input logic o, input logic a, input logic b);
    res_hi = h; res_lo = l; ovl = o; fh = a; fl = b; res_valid = 1;
    model_push(h, l);
    @(negedge clk) res_valid = 0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_hi[i] = 0; m_lo[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 / R9 reset state
    chk({15'd0, int_w}, 16'd1, "R9 reset idle level");
    rd_at(4'hC, 16'h0000, "R11 status after reset");
    rd_at(4'h6, 16'h0000, "R11 history after reset");
    rd_at(4'hA, 16'h0001, "R6 config reset");
    // R6 masked readback
    wreg(4'hA, 16'hFFFF);
    rd_at(4'hA, 16'h001D, "R6 config readback");
    wreg(4'hA, 16'h0001);

    // R1 five results, oldest drops out; mode 0 alert on flagged results (R7)
    conv(16'h1111, 16'h1001, 0, 0, 0);
    conv(16'h2222, 16'h2002, 0, 1, 0);
    conv(16'h3333, 16'h3003, 0, 0, 0);
    conv(16'h4444, 16'h4004, 0, 0, 0);
    conv(16'h5555, 16'h5005, 1, 0, 1);
    chk({15'd0, int_w}, 16'd0, "R7 alert mode raised (active low)");
    set_ptr(4'h0);
    for (int i = 0; i < 8; i++)
      rd_exp(i[0] ? m_lo[i/2] : m_hi[i/2], $sformatf("R1 burst word %0d", i));
    rd_exp(16'h0000, "R10 burst into unmapped 8");
    // R5 / R4 status read, then cleared
    rd_at(4'hC, 16'h000D, "R5 status flags");
    chk({15'd0, int_w}, 16'd1, "R8 status read releases irq");
    rd_at(4'hC, 16'h0009, "R4 ready cleared by read");

    // R4 write behaviour
    conv(16'h6666, 16'h6006, 0, 0, 0);
    wreg(4'hC, 16'h0000);
    rd_at(4'hC, 16'h0004, "R4 zero write keeps ready");
    conv(16'h7777, 16'h7007, 0, 0, 0);
    wreg(4'hC, 16'h0005);
    rd_at(4'hC, 16'h0000, "R4 nonzero write clears ready");

    // R2 auto-increment disabled: pointer holds
    wreg(4'hA, 16'h0000);
    set_ptr(4'h2);
    rd_exp(m_hi[1], "R2 hold first");
    rd_exp(m_hi[1], "R2 hold second");

    // R9 polarity high, mode 1 (R7), release only by read (R8)
    wreg(4'hA, 16'h0015);
    chk({15'd0, int_w}, 16'd0, "R9 active-high idle");
    conv(16'h8888, 16'h8008, 0, 0, 0);
    chk({15'd0, int_w}, 16'd1, "R7 each-result irq");
    wreg(4'hC, 16'h0001);
    chk({15'd0, int_w}, 16'd1, "R8 write does not release");
    rd_at(4'hC, 16'h0000, "R4 status after write clear");
    chk({15'd0, int_w}, 16'd0, "R8 read releases");
    // R4 / R8 result in same cycle as status read
    set_ptr(4'hC);
    rd = 1; exp_q.push_back(16'h0000); tag_q.push_back("R4 read during result");
    res_hi = 16'h9999; res_lo = 16'h9009; ovl = 0; fh = 0; fl = 0; res_valid = 1;
    model_push(16'h9999, 16'h9009);
    @(negedge clk) begin rd = 0; res_valid = 0; end
    chk({15'd0, int_w}, 16'd1, "R8 new event wins over read");
    rd_at(4'hC, 16'h0004, "R4 set wins over clear");
    chk({15'd0, int_w}, 16'd0, "R8 released");

    // R7 mode 3: every fourth result since config write
    wreg(4'hA, 16'h001D);
    conv(16'hA001, 16'h0A01, 0, 0, 0);
    conv(16'hA002, 16'h0A02, 0, 0, 0);
    conv(16'hA003, 16'h0A03, 0, 0, 0);
    chk({15'd0, int_w}, 16'd0, "R7 quad silent for three");
    conv(16'hA004, 16'h0A04, 0, 0, 0);
    chk({15'd0, int_w}, 16'd1, "R7 quad fires on fourth");
    rd_at(4'hC, 16'h0004, "R3 ready after quad");
    chk({15'd0, int_w}, 16'd0, "R8 quad released");
    rd_at(4'h4, m_hi[2], "R1 slot1 high after shifts");
    rd_at(4'h7, m_lo[3], "R1 slot2 low after shifts");

    // R7 mode 2 never
    wreg(4'hA, 16'h0019);
    conv(16'hB001, 16'h0B01, 1, 1, 1);
    chk({15'd0, int_w}, 16'd0, "R7 mode 2 silent");
    // R7 mode 0 alert
    wreg(4'hA, 16'h0011);
    conv(16'hB002, 16'h0B02, 0, 0, 0);
    chk({15'd0, int_w}, 16'd0, "R7 alert no flag");
    conv(16'hB003, 16'h0B03, 0, 1, 0);
    chk({15'd0, int_w}, 16'd1, "R7 alert high flag");

    // R10 unmapped reads and ignored writes
    rd_at(4'h9, 16'h0000, "R10 unmapped 9");
    rd_at(4'hF, 16'h0000, "R10 unmapped F");
    wreg(4'h0, 16'hFFFF);
    wreg(4'hE, 16'hFFFF);
    rd_at(4'h0, m_hi[0], "R10 history write ignored");
    rd_at(4'hA, 16'h0011, "R10 config untouched");

    repeat (4) @(negedge clk);
    chk(16'(exp_q.size()), 16'd0, "R2 all reads returned");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule